// File: doc/BRIEF.md
# Cooperative Jump-and-Link Task Switcher

This unit carries out the control-flow side of one multi-purpose branch instruction. The instruction can act as a jump, a call, a return or a round-robin task switch. In the call form it builds a link word and asks the register file to store that word at a destination address. The link word packs the return address (the current PC plus one) with the zero and carry flags. In the same instruction it branches to a target taken from the source word. Independent enables for Z and C let a return restore either flag from the two low bits of the word it jumps through. A small window of destination addresses, the read-only input registers, blocks the link write, so the same instruction serves as a plain jump or return.

The task-switch form walks a ring of link registers with a pointer that advances before it is used. In one instruction it saves the outgoing task's PC and flags into the current slot. It then moves the pointer, wrapping from the last slot back to the first, and resumes the next slot's PC and flags. A setup command loads the ring bounds and places the pointer at the first slot. The register file and instruction fetch are outside this block. The unit issues a write request and a read address, and it receives read data back in the same cycle.

Top module: `jlink_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit clears `pc`, `flag_z`, `flag_c` and `ring_ptr`, and it sets both ring bounds to 0.
- R2: In a jump cycle (`op_valid`=1, `op_task`=0, `cfg_valid`=0) whose destination is outside the reserved window, the unit raises `wr_en` in that same cycle with `wr_addr`=`dst_addr`. The link word `wr_data` carries `pc`+1 in bits [10:2], `flag_z` in bit 1, `flag_c` in bit 0, and zeros in every bit above bit 10.
- R3: A link-write address from 0x1F4 to 0x1F7 inclusive keeps `wr_en` low, and the branch still takes place. The addresses 0x1F3 and 0x1F8 are written normally.
- R4: In the cycle after a jump, `pc` equals bits [10:2] of `src_word`.
- R5: When `wz_en` is 1 in a jump, `flag_z` takes bit 1 of `src_word`. When `wc_en` is 1, `flag_c` takes bit 0. The two enables act independently.
- R6: When the enable for a flag is 0 in a jump, that flag keeps its value, whatever `src_word` holds.
- R7: A task switch (`op_valid`=1, `op_task`=1, `cfg_valid`=0) writes the link word of R2 to `wr_addr`=`ring_ptr`. It then advances `ring_ptr` to the next slot and loads `pc` from bits [10:2] of that slot's word. It always loads both flags from bits 1 and 0 of the same word, whatever `wz_en` and `wc_en` hold.
- R8: The next slot, shown on `rd_addr`, is `ring_ptr`+1. When `ring_ptr` equals the ring end, the next slot is the ring start.
- R9: In a ring of one slot, a task switch resumes at the saved `pc`+1 with unchanged flags. The unit forwards the word being written in place of the stale read data.
- R10: A setup cycle (`cfg_valid`=1) loads `ring_ptr` and the ring start from `cfg_start` and the ring end from `cfg_end`. Any operation in that cycle is ignored: there is no write, and `pc` and the flags do not change.
- R11: A cycle with `adv`=1 and no operation taking effect increments `pc` by one, modulo 2^9, and leaves the flags unchanged.
- R12: With `op_valid` low, `wr_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Branch instruction issued this cycle |
| op_task | input | 1 | 1 = task-switch form, 0 = jump-with-link form |
| dst_addr | input | 9 | Link register address for the jump form |
| src_word | input | 11 | Source word for the jump form: target in [10:2], Z in [1], C in [0] |
| wz_en | input | 1 | Restore Z from the source word (jump form) |
| wc_en | input | 1 | Restore C from the source word (jump form) |
| adv | input | 1 | Sequential instruction: advance the PC by one |
| cfg_valid | input | 1 | Ring setup command |
| cfg_start | input | 9 | Address of the first ring slot |
| cfg_end | input | 9 | Address of the last ring slot |
| rd_data | input | 11 | Low bits of the register file word at `rd_addr` |
| rd_addr | output | 9 | Ring slot to resume next |
| wr_en | output | 1 | Link write request |
| wr_addr | output | 9 | Link write address |
| wr_data | output | 32 | Link word |
| pc | output | 9 | Program counter |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| ring_ptr | output | 9 | Current ring slot |

## Verification
A wrong ring pointer or a wrong ring bound shows up in the same cycle as a wrong `rd_addr` or `wr_addr` on the next task switch. One switch later it shows up as a wrong resumed `pc` or wrong resumed flags. A stale PC or stale flags show up at once in the next link word, because `wr_data` is built from them combinationally. The bench runs a three-slot ring for four rounds, with uneven task lengths. Any state that goes astray therefore reaches the ports within a few cycles, and it is caught on the clock where it appears.

// File: rtl/jlink_pkg.sv
// Shared definitions for the jump-and-link unit.
// Assumes: the link word places C in bit 0, Z in bit 1 and the return PC above them.
package jlink_pkg;
    localparam int LINK_C_BIT  = 0;
    localparam int LINK_Z_BIT  = 1;
    localparam int LINK_PC_LSB = 2;

    typedef struct packed {
        logic z;
        logic c;
    } flags_t;
endpackage

// File: rtl/jlink_link_fmt.sv
// Builds the link word from the PC and flags, and decides whether the link
// address falls inside the reserved no-write window.
// Assumes: DW > PCW + 2 and RSV_BASE + RSV_CNT <= 2**AW.
module jlink_link_fmt
    import jlink_pkg::*;
#(
    parameter int AW       = 9,
    parameter int PCW      = 9,
    parameter int DW       = 32,
    parameter int RSV_BASE = 'h1F4,
    parameter int RSV_CNT  = 4
) (
    input  logic [PCW-1:0] pc,
    input  flags_t         flags,
    input  logic [AW-1:0]  link_addr,
    output logic [DW-1:0]  link_word,
    output logic           no_write
);
    localparam int LW = PCW + 2;
    localparam logic [AW:0] WIN_LO = (AW+1)'(RSV_BASE);
    localparam logic [AW:0] WIN_HI = (AW+1)'(RSV_BASE + RSV_CNT);

    logic [PCW-1:0] ret_pc;

    // Return address and packed link word
    always_comb begin
        ret_pc    = pc + 1'b1;
        link_word = {{(DW-LW){1'b0}}, ret_pc, flags.z, flags.c};
    end

    // Reserved window decode
    always_comb begin
        no_write = ({1'b0, link_addr} >= WIN_LO) && ({1'b0, link_addr} < WIN_HI);
    end
endmodule

// File: rtl/jlink_ring_ptr.sv
// Holds the ring bounds and the current slot pointer, and offers the
// pre-incremented next slot with wrap from the end back to the start.
// Assumes: software programs start <= end.
module jlink_ring_ptr #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_valid,
    input  logic [AW-1:0] cfg_start,
    input  logic [AW-1:0] cfg_end,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] ptr_next
);
    logic [AW-1:0] start_q;
    logic [AW-1:0] end_q;

    // Next slot with wrap
    always_comb begin
        ptr_next = (ptr == end_q) ? start_q : ptr + 1'b1;
    end

    // Bounds and pointer registers; setup wins over a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            start_q <= '0;
            end_q   <= '0;
        end else if (cfg_valid) begin
            ptr     <= cfg_start;
            start_q <= cfg_start;
            end_q   <= cfg_end;
        end else if (step) begin
            ptr <= ptr_next;
        end
    end
endmodule

// File: rtl/jlink_ctx.sv
// Program counter and flag registers of the running context.
// Assumes: a load has priority over sequential advance.
module jlink_ctx
    import jlink_pkg::*;
#(
    parameter int PCW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_pc,
    input  logic [PCW-1:0] new_pc,
    input  logic           adv,
    input  logic           load_z,
    input  logic           load_c,
    input  flags_t         new_flags,
    output logic [PCW-1:0] pc,
    output flags_t         flags
);
    // PC register: branch load or step by one
    always_ff @(posedge clk) begin
        if (!rst_n)       pc <= '0;
        else if (load_pc) pc <= new_pc;
        else if (adv)     pc <= pc + 1'b1;
    end

    // Flag registers with separate load enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            if (load_z) flags.z <= new_flags.z;
            if (load_c) flags.c <= new_flags.c;
        end
    end
endmodule

// File: rtl/jlink_unit.sv
// Branch-and-link unit: one instruction performs jump, call, return or a
// cooperative round-robin task switch through a ring of link registers.
// Assumes: the register file reads combinationally (rd_addr -> rd_data) and
// commits wr_en/wr_addr/wr_data at the clock edge closing the cycle.
module jlink_unit
    import jlink_pkg::*;
#(
    parameter int AW       = 9,
    parameter int PCW      = 9,
    parameter int DW       = 32,
    parameter int RSV_BASE = 'h1F4,
    parameter int RSV_CNT  = 4,
    localparam int LW      = PCW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic           op_task,
    input  logic [AW-1:0]  dst_addr,
    input  logic [LW-1:0]  src_word,
    input  logic           wz_en,
    input  logic           wc_en,
    input  logic           adv,
    input  logic           cfg_valid,
    input  logic [AW-1:0]  cfg_start,
    input  logic [AW-1:0]  cfg_end,
    input  logic [LW-1:0]  rd_data,
    output logic [AW-1:0]  rd_addr,
    output logic           wr_en,
    output logic [AW-1:0]  wr_addr,
    output logic [DW-1:0]  wr_data,
    output logic [PCW-1:0] pc,
    output logic           flag_z,
    output logic           flag_c,
    output logic [AW-1:0]  ring_ptr
);
    logic          op_go;
    logic          task_go;
    logic [AW-1:0] ptr_next;
    logic [AW-1:0] link_addr;
    logic [DW-1:0] link_word;
    logic          no_write;
    logic          fwd;
    logic [LW-1:0] load_word;
    flags_t        cur_flags;
    flags_t        new_flags;

    // Instruction qualification: setup suppresses any operation
    always_comb begin
        op_go     = op_valid && !cfg_valid;
        task_go   = op_go && op_task;
        link_addr = op_task ? ring_ptr : dst_addr;
    end

    jlink_ring_ptr #(.AW(AW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_start (cfg_start),
        .cfg_end   (cfg_end),
        .step      (task_go),
        .ptr       (ring_ptr),
        .ptr_next  (ptr_next)
    );

    jlink_link_fmt #(
        .AW(AW), .PCW(PCW), .DW(DW), .RSV_BASE(RSV_BASE), .RSV_CNT(RSV_CNT)
    ) u_fmt (
        .pc        (pc),
        .flags     (cur_flags),
        .link_addr (link_addr),
        .link_word (link_word),
        .no_write  (no_write)
    );

    // Write request and source selection with same-slot forwarding
    always_comb begin
        wr_en     = op_go && !no_write;
        wr_addr   = link_addr;
        wr_data   = link_word;
        rd_addr   = ptr_next;
        fwd       = task_go && wr_en && (ptr_next == link_addr);
        load_word = op_task ? (fwd ? link_word[LW-1:0] : rd_data) : src_word;
        new_flags = '{z: load_word[LINK_Z_BIT], c: load_word[LINK_C_BIT]};
    end

    jlink_ctx #(.PCW(PCW)) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_pc   (op_go),
        .new_pc    (load_word[LW-1:LINK_PC_LSB]),
        .adv       (adv),
        .load_z    (op_go && (op_task || wz_en)),
        .load_c    (op_go && (op_task || wc_en)),
        .new_flags (new_flags),
        .pc        (pc),
        .flags     (cur_flags)
    );

    // Flag outputs
    always_comb begin
        flag_z = cur_flags.z;
        flag_c = cur_flags.c;
    end
endmodule

// File: rtl/jlink_unit_chk.sv
// Property checker for jlink_unit, attached by bind below.
// Assumes: the same parameter values as the unit it observes.
module jlink_unit_chk #(
    parameter int AW       = 9,
    parameter int PCW      = 9,
    parameter int DW       = 32,
    parameter int RSV_BASE = 'h1F4,
    parameter int RSV_CNT  = 4,
    localparam int LW      = PCW + 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           op_valid,
    input logic           op_task,
    input logic [AW-1:0]  dst_addr,
    input logic [LW-1:0]  src_word,
    input logic           wz_en,
    input logic           wc_en,
    input logic           adv,
    input logic           cfg_valid,
    input logic [AW-1:0]  cfg_start,
    input logic [AW-1:0]  rd_addr,
    input logic           wr_en,
    input logic [AW-1:0]  wr_addr,
    input logic [DW-1:0]  wr_data,
    input logic [PCW-1:0] pc,
    input logic           flag_z,
    input logic           flag_c,
    input logic [AW-1:0]  ring_ptr
);
    logic jump_go;
    logic task_go;
    logic in_win;

    // Decoded cycle kinds for the properties
    always_comb begin
        jump_go = op_valid && !cfg_valid && !op_task;
        task_go = op_valid && !cfg_valid && op_task;
        in_win  = (int'(dst_addr) >= RSV_BASE) && (int'(dst_addr) < RSV_BASE + RSV_CNT);
    end

    p_link_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[1:0] == {flag_z, flag_c}) && (wr_data[LW-1:2] == pc + 1'b1));
    p_link_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_data[DW-1:LW] == '0);
    p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_go && in_win) |-> !wr_en);
    p_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        jump_go |=> pc == $past(src_word[LW-1:2]));
    p_zload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_go && wz_en) |=> flag_z == $past(src_word[1]));
    p_zhold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_go && !wz_en) |=> $stable(flag_z));
    p_chold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_go && !wc_en) |=> $stable(flag_c));
    p_save_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (task_go && wr_en) |-> wr_addr == ring_ptr);
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        task_go |=> ring_ptr == $past(rd_addr));
    p_setup_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> ring_ptr == $past(cfg_start));
    p_setup_nowr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> !wr_en);
    p_adv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !(op_valid && !cfg_valid)) |=> pc == $past(pc) + 1'b1);
    p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !wr_en);
endmodule

bind jlink_unit jlink_unit_chk #(
    .AW(AW), .PCW(PCW), .DW(DW), .RSV_BASE(RSV_BASE), .RSV_CNT(RSV_CNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_task   (op_task),
    .dst_addr  (dst_addr),
    .src_word  (src_word),
    .wz_en     (wz_en),
    .wc_en     (wc_en),
    .adv       (adv),
    .cfg_valid (cfg_valid),
    .cfg_start (cfg_start),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pc        (pc),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .ring_ptr  (ring_ptr)
);

// File: tb/test_jlink_unit.sv
// Self-checking bench: behavioural model of PC, flags, ring and register
// file, compared with the unit on every clock.
module test_jlink_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_task = 1'b0;
    logic [8:0]  dst_addr = '0;
    logic [10:0] src_word = '0;
    logic        wz_en = 1'b0;
    logic        wc_en = 1'b0;
    logic        adv = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [8:0]  cfg_start = '0;
    logic [8:0]  cfg_end = '0;
    logic [10:0] rd_data;
    logic [8:0]  rd_addr;
    logic        wr_en;
    logic [8:0]  wr_addr;
    logic [31:0] wr_data;
    logic [8:0]  pc;
    logic        flag_z;
    logic        flag_c;
    logic [8:0]  ring_ptr;

    logic [31:0] rf   [0:511];
    logic [31:0] m_rf [0:511];
    logic [8:0]  m_pc, m_ptr, m_start, m_end;
    logic        m_z, m_c;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    jlink_unit i_jlink_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_task(op_task),
        .dst_addr(dst_addr), .src_word(src_word), .wz_en(wz_en), .wc_en(wc_en),
        .adv(adv), .cfg_valid(cfg_valid), .cfg_start(cfg_start), .cfg_end(cfg_end),
        .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pc(pc), .flag_z(flag_z), .flag_c(flag_c),
        .ring_ptr(ring_ptr)
    );

    // Register file environment
    assign rd_data = rf[rd_addr][10:0];
    always @(posedge clk) if (wr_en) rf[wr_addr] <= wr_data;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] lw(input logic [8:0] p, input logic z, input logic c);
        return {21'd0, p, z, c};
    endfunction

    // One cycle: inputs already set at a falling edge
    task automatic tick(input string tag);
        logic go, sup, we;
        logic [8:0] dx, nxt;
        logic [31:0] link, word;
        #1;
        go   = op_valid && !cfg_valid;
        dx   = op_task ? m_ptr : dst_addr;
        sup  = (dx >= 9'h1F4) && (dx <= 9'h1F7);
        we   = go && !sup;
        link = lw(m_pc + 9'd1, m_z, m_c);
        chk(!go ? (cfg_valid ? "R10" : "R12") : (sup ? "R3" : "R2"), 32'(wr_en), 32'(we));
        if (we) begin
            chk(op_task ? "R7" : "R2", 32'(wr_addr), 32'(dx));
            chk("R2", wr_data, link);
        end
        nxt = (m_ptr == m_end) ? m_start : m_ptr + 9'd1;
        if (go && op_task) chk("R8", 32'(rd_addr), 32'(nxt));
        if (we) m_rf[dx] = link;
        if (go) begin
            word = op_task ? m_rf[nxt] : {21'd0, src_word};
            m_pc = word[10:2];
            if (op_task || wz_en) m_z = word[1];
            if (op_task || wc_en) m_c = word[0];
            if (op_task) m_ptr = nxt;
        end else if (adv) begin
            m_pc = m_pc + 9'd1;
        end
        if (cfg_valid) begin
            m_ptr = cfg_start; m_start = cfg_start; m_end = cfg_end;
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, 32'(pc), 32'(m_pc));
        chk(tag, 32'(flag_z), 32'(m_z));
        chk(tag, 32'(flag_c), 32'(m_c));
        chk(tag, 32'(ring_ptr), 32'(m_ptr));
        op_valid = 0; op_task = 0; wz_en = 0; wc_en = 0; adv = 0; cfg_valid = 0;
    endtask

    task automatic jump(input logic [8:0] d, input logic [10:0] s,
                        input logic ez, input logic ec, input string tag);
        op_valid = 1; op_task = 0; dst_addr = d; src_word = s; wz_en = ez; wc_en = ec;
        tick(tag);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) begin rf[i] = '0; m_rf[i] = '0; end
        rf[9'h11] = lw(9'd40, 1'b1, 1'b0);  m_rf[9'h11] = rf[9'h11];
        rf[9'h12] = lw(9'd80, 1'b0, 1'b1);  m_rf[9'h12] = rf[9'h12];
        m_pc = '0; m_z = 0; m_c = 0; m_ptr = '0; m_start = '0; m_end = '0;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", 32'(pc), 0);
        chk("R1", 32'(flag_z), 0);
        chk("R1", 32'(flag_c), 0);
        chk("R1", 32'(ring_ptr), 0);
        rst_n = 1'b1;

        // R11: sequential advance
        repeat (3) begin adv = 1; tick("R11"); end
        // R2 R4 R5: call storing link at 0x20, target 100, flags 1/1
        jump(9'h020, {9'd100, 2'b11}, 1, 1, "R4");
        // R5 R6: only C restored
        jump(9'h021, {9'd50, 2'b00}, 0, 1, "R6");
        // R6: neither flag restored
        jump(9'h022, {9'd60, 2'b11}, 0, 0, "R6");
        // R4 R5: return through the link saved at 0x20
        jump(9'h1F5, rf[9'h020][10:0], 1, 1, "R4");
        // R3: window edges
        jump(9'h1F4, {9'd7, 2'b10}, 1, 0, "R3");
        jump(9'h1F7, {9'd9, 2'b01}, 0, 1, "R3");
        jump(9'h1F3, {9'd11, 2'b00}, 0, 0, "R3");
        jump(9'h1F8, {9'd13, 2'b11}, 1, 1, "R3");
        // R12: idle cycles
        repeat (2) tick("R12");
        // R10: setup with a colliding jump, which is ignored
        cfg_valid = 1; cfg_start = 9'h010; cfg_end = 9'h012;
        op_valid = 1; dst_addr = 9'h023; src_word = {9'd200, 2'b11}; wz_en = 1; wc_en = 1;
        tick("R10");
        // R7 R8: three-slot ring, four rounds, forced flag restore
        for (int r = 0; r < 4; r++) begin
            for (int t = 0; t < 3; t++) begin
                repeat (t + 1) begin adv = 1; tick("R11"); end
                op_valid = 1; op_task = 1;
                tick("R7");
            end
        end
        // R9: one-slot ring
        cfg_valid = 1; cfg_start = 9'h030; cfg_end = 9'h030;
        tick("R10");
        jump(9'h024, {9'd300, 2'b10}, 1, 1, "R5");
        op_valid = 1; op_task = 1; tick("R9");
        adv = 1; tick("R11");
        op_valid = 1; op_task = 1; tick("R9");
        tick("R12");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule